// File: doc/BRIEF.md
# Watchdog Timer with Guarded Reconfiguration

This block watches for software that stops making progress. A counter advances on a slow tick that comes from a separate low-frequency oscillator. The tick is already synchronized to the system clock and arrives as a one-cycle enable. Software must restart the counter with a kick strobe before a selected time-out is reached. If it does not, the block raises an interrupt flag, emits a one-cycle system reset pulse, or does both in turn: an interrupt first, then a reset on the next expiry.

Software configures the block through a single byte-wide write port. It reads the live settings back on a byte-wide status output. Setting the reset enable, writing the interrupt enable and clearing the flag all take effect at once. Clearing the reset enable or changing the time-out code takes two writes. The first is an unlock write, and it opens a short window. The second is the commit write, and it must land inside that window. A lock input, driven from a fuse, pins the block in reset-only mode.

Top module: `wdog_core`

## Requirements
- R1: After reset, `cfg_o` reads 8'h00 and `irq_o` and `rst_o` are low.
- R2: The counter advances only on cycles with `tick_i` high, and only while the interrupt enable or the reset enable is set. With both enables clear, or with no ticks, nothing ever fires.
- R3: An expiry occurs on the tick that completes 2^(BASE_LOG+c) ticks since the last kick or expiry, where c is the time-out code in write bits [7:4] (read back in `cfg_o[7:4]`). A `kick_i` pulse restarts the count from zero.
- R4: With the interrupt enable set (write bit 0) and the reset enable clear, an expiry sets the flag (`cfg_o[3]`). `irq_o` is high while both the flag and the interrupt enable are set.
- R5: The flag is cleared by a write with bit 3 set, or by `irq_ack_i`. In interrupt-only mode the acknowledge leaves the interrupt enable set.
- R6: With the reset enable set (`cfg_o[1]`) and the interrupt enable clear, an expiry drives `rst_o` high for exactly one cycle, in the cycle after the expiring edge.
- R7: With both enables set, an expiry with the flag clear sets the flag and does not reset. An expiry with the flag still set produces the reset pulse. In this mode `irq_ack_i` clears both the flag and the interrupt enable, which leaves reset-only mode.
- R8: A write with bit 2 and bit 1 both set is an unlock write. It opens a window of WIN_CYCLES cycles, and `cfg_o[2]` reads 1 while the window is open. An unlock write with bit 1 clear opens no window.
- R9: A write with bit 2 clear, on any of the WIN_CYCLES edges after the unlock edge, loads the reset enable from bit 1 and the code from bits [7:4], and closes the window. A write one edge later leaves the code and reset enable unchanged.
- R10: Outside the window, a write cannot clear the reset enable or change the code, but it can set the reset enable.
- R11: Codes 10 to 15 read back as written and time out like code 9.
- R12: While `fuse_i` is high, `cfg_o[1:0]` reads 2'b10, `irq_o` stays low and expiries produce reset pulses. The code can still be changed through the unlock sequence.
- R13: The counter restarts from zero after each expiry, including one that produces a reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Synchronized slow-oscillator tick enable |
| fuse_i | input | 1 | Lock into reset-only mode |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 8 | Write data: [0] irq enable, [1] reset enable, [2] change enable, [3] flag clear, [7:4] code |
| kick_i | input | 1 | Counter restart strobe |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| cfg_o | output | 8 | Readback: [0] irq enable, [1] reset enable, [2] window open, [3] flag, [7:4] code |
| irq_o | output | 1 | Interrupt request |
| rst_o | output | 1 | One-cycle system reset request |

## Verification
A miscounting counter shows up as an expiry exactly one or more cycles away from 2^(BASE_LOG+c) edges after a kick. The checks therefore sample the edge before and the edge of the expected expiry. A window counter that is off by one shows up as an accepted or rejected commit at the fourth or fifth edge after the unlock, and both edges are probed through the readback. A mode register that holds the wrong value appears on the next expiry as a reset where an interrupt belongs, or the reverse. A stuck flag appears at once in `cfg_o[3]`.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned MAX_CODE = 9;

  localparam int unsigned B_IRQ  = 0;
  localparam int unsigned B_RST  = 1;
  localparam int unsigned B_CHG  = 2;
  localparam int unsigned B_FLAG = 3;
  localparam int unsigned B_PS   = 4;

  typedef logic [CODE_W-1:0] ps_code_t;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_IRQ  = 2'b01,
    MODE_RST  = 2'b10,
    MODE_BOTH = 2'b11
  } mode_e;

  function automatic ps_code_t sat_code(ps_code_t c);
    return (c > ps_code_t'(MAX_CODE)) ? ps_code_t'(MAX_CODE) : c;
  endfunction
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_LOG = 11,
  parameter int unsigned CNT_W    = BASE_LOG + MAX_CODE
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     en_i,
  input  logic     kick_i,
  input  ps_code_t ps_i,
  output logic     expire_o
);
  localparam logic [CNT_W:0]   LIM_ONE = 1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   lim_m1;
  int unsigned      shamt;

  always_comb begin
    shamt  = BASE_LOG + int'(sat_code(ps_i));
    lim_m1 = (LIM_ONE << shamt) - LIM_ONE;
  end

  assign expire_o = en_i & tick_i & ~kick_i & ({1'b0, cnt_q} >= lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!en_i || kick_i || expire_o) cnt_q <= '0;
    else if (tick_i)                      cnt_q <= cnt_q + CNT_ONE;
  end

  // R3
  kick_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q == '0));
  // R13
  expire_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == '0));
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !kick_i && en_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter int unsigned WIN_CYCLES = 4,
  parameter int unsigned WIN_W      = $clog2(WIN_CYCLES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fuse_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       ack_i,
  input  logic       set_flag_i,
  output logic       irq_en_o,
  output logic       rst_en_o,
  output logic       flag_o,
  output logic       win_open_o,
  output ps_code_t   ps_o
);
  localparam logic [WIN_W-1:0] WIN_LOAD = WIN_W'(WIN_CYCLES);
  localparam logic [WIN_W-1:0] WIN_ONE  = 1;

  logic [WIN_W-1:0] win_q;
  ps_code_t         ps_q;
  logic             irq_en_q, rst_en_q, flag_q;
  logic             unlock, commit;

  assign unlock = wr_en_i & wr_data_i[B_CHG] & wr_data_i[B_RST];
  assign commit = wr_en_i & ~wr_data_i[B_CHG] & (win_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q    <= '0;
      ps_q     <= '0;
      irq_en_q <= 1'b0;
      rst_en_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (unlock)            win_q <= WIN_LOAD;
      else if (commit)       win_q <= '0;
      else if (win_q != '0)  win_q <= win_q - WIN_ONE;

      if (commit) ps_q <= wr_data_i[B_PS +: CODE_W];

      if (fuse_i)                          rst_en_q <= 1'b1;
      else if (commit)                     rst_en_q <= wr_data_i[B_RST];
      else if (wr_en_i && wr_data_i[B_RST]) rst_en_q <= 1'b1;

      if (fuse_i)                irq_en_q <= 1'b0;
      else if (wr_en_i)          irq_en_q <= wr_data_i[B_IRQ];
      else if (ack_i && rst_en_q) irq_en_q <= 1'b0;

      if (set_flag_i)                              flag_q <= 1'b1;
      else if (ack_i || (wr_en_i && wr_data_i[B_FLAG])) flag_q <= 1'b0;
    end
  end

  assign irq_en_o   = irq_en_q & ~fuse_i;
  assign rst_en_o   = rst_en_q | fuse_i;
  assign flag_o     = flag_q;
  assign win_open_o = (win_q != '0);
  assign ps_o       = ps_q;

  // R9
  ps_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q == '0) |=> $stable(ps_q));
  // R10
  rst_en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_en_q && win_q == '0) |=> rst_en_q);
  // R8
  win_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_q <= WIN_LOAD);
endmodule

// File: rtl/wdog_action.sv
module wdog_action
  import wdog_pkg::*;
(
  input  logic expire_i,
  input  logic irq_en_i,
  input  logic rst_en_i,
  input  logic flag_i,
  output logic set_flag_o,
  output logic fire_rst_o
);
  mode_e mode;

  assign mode = mode_e'({rst_en_i, irq_en_i});

  always_comb begin
    set_flag_o = 1'b0;
    fire_rst_o = 1'b0;
    unique case (mode)
      MODE_IRQ:  set_flag_o = expire_i;
      MODE_RST:  fire_rst_o = expire_i;
      MODE_BOTH: begin
        // first expiry interrupts, a second one with the flag pending resets
        set_flag_o = expire_i & ~flag_i;
        fire_rst_o = expire_i &  flag_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_LOG   = 11,
  parameter int unsigned WIN_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       fuse_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       kick_i,
  input  logic       irq_ack_i,
  output logic [7:0] cfg_o,
  output logic       irq_o,
  output logic       rst_o
);
  localparam int unsigned CNT_W = BASE_LOG + MAX_CODE;

  logic     irq_en, rst_en, flag, win_open;
  ps_code_t ps;
  logic     expire, set_flag, fire_rst;
  logic     rst_q;

  wdog_cfg #(.WIN_CYCLES(WIN_CYCLES)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fuse_i     (fuse_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .ack_i      (irq_ack_i),
    .set_flag_i (set_flag),
    .irq_en_o   (irq_en),
    .rst_en_o   (rst_en),
    .flag_o     (flag),
    .win_open_o (win_open),
    .ps_o       (ps)
  );

  wdog_counter #(.BASE_LOG(BASE_LOG), .CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .en_i     (irq_en | rst_en),
    .kick_i   (kick_i),
    .ps_i     (ps),
    .expire_o (expire)
  );

  wdog_action u_act (
    .expire_i   (expire),
    .irq_en_i   (irq_en),
    .rst_en_i   (rst_en),
    .flag_i     (flag),
    .set_flag_o (set_flag),
    .fire_rst_o (fire_rst)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b0;
    else         rst_q <= fire_rst;
  end

  assign rst_o = rst_q;
  assign irq_o = flag & irq_en;
  assign cfg_o = {ps, flag, win_open, rst_en, irq_en};

  // R6
  rst_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |=> !rst_o);
  // R12
  fuse_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fuse_i |-> !irq_o);
  // R7
  both_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_rst && irq_en) |-> flag);
  // R4
  flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag) |-> $past(expire));
endmodule

// File: tb/wdog_core_test.sv
module wdog_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_LOG   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       fuse = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       kick = 1'b0;
  logic       ack = 1'b0;
  logic [7:0] cfg;
  logic       irq, rst;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_core #(.BASE_LOG(BASE_LOG), .WIN_CYCLES(4)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_i    (tick),
    .fuse_i    (fuse),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .kick_i    (kick),
    .irq_ack_i (ack),
    .cfg_o     (cfg),
    .irq_o     (irq),
    .rst_o     (rst)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic kick_pulse();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic ack_pulse();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  // unlock then commit, kicking throughout; also clears the flag
  task automatic cfg_set(logic irq_b, logic rst_b, logic [3:0] code);
    kick = 1'b1; wr_en = 1'b1;
    wr_data = {4'h0, 1'b1, 1'b1, 1'b1, irq_b};
    @(negedge clk);
    wr_data = {code, 1'b1, 1'b0, rst_b, irq_b};
    @(negedge clk);
    kick = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic expect_timeout(int len, string req, bit is_rst);
    kick_pulse();
    repeat (len - 1) @(negedge clk);
    chk(req, is_rst ? rst : irq, 0);
    @(negedge clk);
    chk(req, is_rst ? rst : irq, 1);
  endtask

  task automatic t_reset();
    chk("R1 cfg", cfg, 8'h00);
    chk("R1 irq", irq, 0);
    chk("R1 rst", rst, 0);
  endtask

  task automatic t_disabled();
    repeat (40) @(negedge clk);
    chk("R2 disabled irq", irq, 0);
    chk("R2 disabled rst", rst, 0);
    chk("R2 disabled cfg", cfg, 8'h00);
  endtask

  task automatic t_irq_mode();
    wr(8'h01);
    chk("R4 irq enable", cfg, 8'h01);
    expect_timeout(4, "R3 R4 code0 irq", 0);
    chk("R4 flag", cfg[3], 1);
    wr(8'h09);
    chk("R5 w1c", cfg[3], 0);
    repeat (3) @(negedge clk);
    chk("R13 refire", cfg[3], 1);
    ack_pulse();
    chk("R5 ack flag", cfg[3], 0);
    chk("R5 ack keeps irq en", cfg[0], 1);
  endtask

  task automatic t_no_tick();
    tick = 1'b0;
    kick_pulse();
    repeat (20) @(negedge clk);
    chk("R2 no tick", irq, 0);
    tick = 1'b1;
    wr(8'h08);
  endtask

  task automatic t_kick();
    wr(8'h09);
    for (int i = 0; i < 10; i++) begin
      kick_pulse();
      repeat (2) @(negedge clk);
    end
    chk("R3 kicked", irq, 0);
    wr(8'h08);
  endtask

  task automatic t_rst_mode();
    wr(8'h02);
    chk("R10 set rst en", cfg[1:0], 2'b10);
    expect_timeout(4, "R6 reset fire", 1);
    @(negedge clk);
    chk("R6 one cycle", rst, 0);
    repeat (2) @(negedge clk);
    chk("R13 early", rst, 0);
    @(negedge clk);
    chk("R13 restart after reset", rst, 1);
  endtask

  task automatic t_locked();
    wr(8'h00);
    chk("R10 clear ignored", cfg[1], 1);
    wr(8'h32);
    chk("R10 code ignored", cfg[7:4], 4'h0);
  endtask

  task automatic t_window();
    wr(8'h06);
    chk("R8 window open", cfg[2], 1);
    repeat (3) @(negedge clk);
    wr(8'h22);
    chk("R9 late accept", cfg[7:4], 4'h2);
    chk("R9 closes window", cfg[2], 0);
    wr(8'h06);
    repeat (4) @(negedge clk);
    chk("R8 window expired", cfg[2], 0);
    wr(8'h52);
    chk("R9 after window", cfg[7:4], 4'h2);
    wr(8'h04);
    chk("R8 no unlock", cfg[2], 0);
  endtask

  task automatic t_both();
    cfg_set(1'b1, 1'b1, 4'h0);
    chk("R7 both cfg", cfg[3:0], 4'h3);
    expect_timeout(4, "R7 first irq", 0);
    chk("R7 no reset first", rst, 0);
    repeat (3) @(negedge clk);
    chk("R7 before second", rst, 0);
    @(negedge clk);
    chk("R7 second resets", rst, 1);
    ack_pulse();
    chk("R7 ack clears irq en", cfg[0], 0);
    chk("R7 ack clears flag", cfg[3], 0);
    expect_timeout(4, "R7 reset mode after ack", 1);
  endtask

  task automatic t_codes();
    cfg_set(1'b1, 1'b0, 4'h3);
    chk("R9 rst cleared", cfg[1], 0);
    expect_timeout(32, "R3 code3", 0);
    cfg_set(1'b1, 1'b0, 4'hF);
    chk("R11 readback", cfg[7:4], 4'hF);
    expect_timeout(2048, "R11 reserved as 9", 0);
  endtask

  task automatic t_fuse();
    cfg_set(1'b1, 1'b0, 4'h0);
    fuse = 1'b1;
    #1;
    chk("R12 forced mode", cfg[1:0], 2'b10);
    @(negedge clk);
    cfg_set(1'b1, 1'b0, 4'h1);
    chk("R12 still forced", cfg[1:0], 2'b10);
    chk("R12 code change", cfg[7:4], 4'h1);
    expect_timeout(8, "R12 fuse reset", 1);
    chk("R12 no irq", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_irq_mode();
    t_no_tick();
    t_kick();
    t_rst_mode();
    t_locked();
    t_window();
    t_both();
    t_codes();
    t_fuse();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule